// File: doc/BRIEF.md
# Programming-Enable and Address-Guard Controller

This block sits beside the serial command front-end of a small non-volatile word memory and decides which programming operations may proceed. It holds two pieces of state: a programming-enable flag and a guard register. The guard register stores a boundary address. Every word at or above that address is read-only. The front-end passes each fully loaded instruction as a one-cycle command, together with the levels of the program-enable pin and the guard-enable pin that were sampled while it was loaded.

The write path queries the block at any time. It presents an address and the program-enable level sampled during its own load. The block answers combinationally whether that single-word write may go ahead and whether a whole-array write may go ahead. It also drives the guard register's contents for read-back. Changes to the guard register follow a strict sequence. First the guard is armed, which needs programming already enabled. Then a clear, a boundary write or a one-time seal must come as the very next command. A sealed guard cannot change again until power-on reset.

The guard address width `AW` is a parameter, intended to be 6 or 8.

Top module: `write_guard_ctrl`

## Requirements
- R1: After reset, `pgm_en` is 0, the guard is open (`guard_addr` all ones), unsealed and unarmed, and both `wr_ok` and `bulk_ok` are 0.
- R2: The command code 1 (program-on) sets `pgm_en` and the code 2 (program-off) clears it. No other command changes `pgm_en`.
- R3: The code 6 (guard-arm) arms the guard only if `pgm_en` is 1 and both `pe_lvl` and `pre_lvl` are 1 in the same cycle as `cmd_valid`.
- R4: The codes 7 (guard-clear), 8 (guard-set) and 9 (guard-seal) act only when the previous command armed the guard and both `pe_lvl` and `pre_lvl` are 1. Every accepted command other than a successful arm leaves the guard disarmed.
- R5: Guard-clear sets `guard_addr` to all ones and opens the guard. While the guard is open, every address including the highest one is writable, and `bulk_ok` follows `pgm_en & chk_pe`.
- R6: Guard-set takes effect only while the guard is open. It stores `cmd_addr` and closes the guard. After that, writes are refused for every address greater than or equal to the stored one, allowed below it, and `bulk_ok` is 0.
- R7: A guard-set with an all-ones address blocks the highest word and whole-array writes, even though `guard_addr` reads the same value as after a clear.
- R8: Guard-seal locks the guard register. After it, guard-clear and guard-set leave `guard_addr` and the open/closed state unchanged. Only `rst_n` removes the lock.
- R9: `wr_ok` is 1 only when `pgm_en` and `chk_pe` are both 1 and `chk_addr` is not guarded. `bulk_ok` needs `pgm_en`, `chk_pe` and an open guard.
- R10: Read commands, code 0 (array read) and code 5 (guard read), change neither `pgm_en` nor the guard contents. `guard_addr` always shows the stored boundary.
- R11: The codes 3 (word write), 4 (whole-array write), 10 to 15 and the codes above act as plain commands. They change no state except to disarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cmd_valid | input | 1 | One-cycle strobe of a decoded command |
| cmd_op | input | 4 | Command code |
| cmd_addr | input | AW | Address field of the command |
| pe_lvl | input | 1 | Program-enable pin level sampled during load |
| pre_lvl | input | 1 | Guard-enable pin level sampled during load |
| chk_addr | input | AW | Address queried by the write path |
| chk_pe | input | 1 | Program-enable level sampled with the queried write |
| pgm_en | output | 1 | Programming-enable state |
| wr_ok | output | 1 | Single-word write to `chk_addr` allowed |
| bulk_ok | output | 1 | Whole-array write allowed |
| guard_addr | output | AW | Stored guard boundary |

## Verification
The in-line properties check, on every cycle, the following rules:
- The effect of the program-on and program-off commands.
- Disarming by any non-arm command.
- The need for `pgm_en` before arming.
- The permanence of the seal.
- The rule that a closed guard's address changes only when it is cleared.
- The refusal of writes at or above a closed boundary.

Only the bench's scenarios can show some other behaviour. These are that commands with a pin level low or with an intervening command are ignored, and that an all-ones boundary differs from the cleared state. They also include full address sweeps, which show the exact boundary, and the lifting of the seal by reset.

// File: rtl/wgc_pkg.sv
package wgc_pkg;

    typedef enum logic [3:0] {
        OP_RD         = 4'd0,
        OP_PGM_ON     = 4'd1,
        OP_PGM_OFF    = 4'd2,
        OP_WR_WORD    = 4'd3,
        OP_WR_BULK    = 4'd4,
        OP_GUARD_RD   = 4'd5,
        OP_GUARD_ARM  = 4'd6,
        OP_GUARD_CLR  = 4'd7,
        OP_GUARD_SET  = 4'd8,
        OP_GUARD_SEAL = 4'd9
    } op_e;

    typedef struct packed {
        logic pgm;
        logic armed;
    } enable_st_t;

endpackage

// File: rtl/wgc_enable_seq.sv
module wgc_enable_seq
    import wgc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_op,
    input  logic       pe_lvl,
    input  logic       pre_lvl,
    output logic       pgm_en,
    output logic       armed
);

    enable_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_valid) begin
            // Arming survives only across one command boundary.
            st_d.armed = (cmd_op == OP_GUARD_ARM) && st_q.pgm && pe_lvl && pre_lvl;
            if (cmd_op == OP_PGM_ON) begin
                st_d.pgm = 1'b1;
            end else if (cmd_op == OP_PGM_OFF) begin
                st_d.pgm = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pgm_en = st_q.pgm;
    assign armed  = st_q.armed;

    p_pgm_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PGM_ON) |=> pgm_en);
    p_pgm_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PGM_OFF) |=> !pgm_en);
    p_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op != OP_GUARD_ARM) |=> !armed);
    p_arm_needs_pgm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !pgm_en) |=> !armed);

endmodule

// File: rtl/wgc_guard_reg.sv
module wgc_guard_reg
    import wgc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic          pe_lvl,
    input  logic          pre_lvl,
    input  logic          armed,
    output logic [AW-1:0] guard_addr,
    output logic          guard_open,
    output logic          sealed
);

    localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          open;
        logic          seal;
    } guard_st_t;

    guard_st_t st_d, st_q;
    logic      go;

    assign go = cmd_valid && armed && pe_lvl && pre_lvl && !st_q.seal;

    always_comb begin
        st_d = st_q;
        if (go) begin
            case (cmd_op)
                OP_GUARD_CLR: begin
                    st_d.addr = ALL_ONES;
                    st_d.open = 1'b1;
                end
                OP_GUARD_SET: begin
                    if (st_q.open) begin
                        st_d.addr = cmd_addr;
                        st_d.open = 1'b0;
                    end
                end
                OP_GUARD_SEAL: st_d.seal = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{addr: ALL_ONES, open: 1'b1, seal: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign guard_addr = st_q.addr;
    assign guard_open = st_q.open;
    assign sealed     = st_q.seal;

    p_seal_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> sealed);
    p_sealed_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> ($stable(guard_addr) && $stable(guard_open)));
    p_closed_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !guard_open |=> (guard_open || $stable(guard_addr)));
    p_unarmed_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> ($stable(guard_addr) && $stable(guard_open) && $stable(sealed)));

endmodule

// File: rtl/wgc_access_check.sv
module wgc_access_check #(
    parameter int AW = 8
) (
    input  logic          pgm_en,
    input  logic          guard_open,
    input  logic [AW-1:0] guard_addr,
    input  logic [AW-1:0] chk_addr,
    input  logic          chk_pe,
    output logic          wr_ok,
    output logic          bulk_ok
);

    logic permit;
    logic in_guard;

    always_comb begin
        permit   = pgm_en && chk_pe;
        in_guard = !guard_open && (chk_addr >= guard_addr);
        wr_ok    = permit && !in_guard;
        bulk_ok  = permit && guard_open;
    end

endmodule

// File: rtl/write_guard_ctrl.sv
module write_guard_ctrl #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic          pe_lvl,
    input  logic          pre_lvl,
    input  logic [AW-1:0] chk_addr,
    input  logic          chk_pe,
    output logic          pgm_en,
    output logic          wr_ok,
    output logic          bulk_ok,
    output logic [AW-1:0] guard_addr
);

    logic armed;
    logic guard_open;
    logic sealed;

    wgc_enable_seq u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .pe_lvl    (pe_lvl),
        .pre_lvl   (pre_lvl),
        .pgm_en    (pgm_en),
        .armed     (armed)
    );

    wgc_guard_reg #(.AW(AW)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .pe_lvl     (pe_lvl),
        .pre_lvl    (pre_lvl),
        .armed      (armed),
        .guard_addr (guard_addr),
        .guard_open (guard_open),
        .sealed     (sealed)
    );

    wgc_access_check #(.AW(AW)) u_check (
        .pgm_en     (pgm_en),
        .guard_open (guard_open),
        .guard_addr (guard_addr),
        .chk_addr   (chk_addr),
        .chk_pe     (chk_pe),
        .wr_ok      (wr_ok),
        .bulk_ok    (bulk_ok)
    );

    p_guarded_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard_open && chk_addr >= guard_addr) |-> !wr_ok);
    p_write_needs_pgm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok || bulk_ok) |-> (pgm_en && chk_pe));
    p_bulk_needs_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_ok |-> guard_open);

endmodule

// File: tb/write_guard_ctrl_bench.sv
module write_guard_ctrl_bench;

    localparam int AW = 6;
    localparam int NW = 1 << AW;
    localparam logic [AW-1:0] TOP = {AW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_op = 4'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic          pe_lvl = 1'b0;
    logic          pre_lvl = 1'b0;
    logic [AW-1:0] chk_addr = '0;
    logic          chk_pe = 1'b1;
    logic          pgm_en, wr_ok, bulk_ok;
    logic [AW-1:0] guard_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // requirement model
    bit            m_pgm, m_armed, m_open, m_seal;
    logic [AW-1:0] m_addr;

    always #2.5 clk = ~clk;

    write_guard_ctrl #(.AW(AW)) u_write_guard_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .pe_lvl(pe_lvl), .pre_lvl(pre_lvl),
        .chk_addr(chk_addr), .chk_pe(chk_pe), .pgm_en(pgm_en),
        .wr_ok(wr_ok), .bulk_ok(bulk_ok), .guard_addr(guard_addr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pgm = 0; m_armed = 0; m_open = 1; m_seal = 0; m_addr = TOP;
    endtask

    task automatic issue(input logic [3:0] op, input logic [AW-1:0] a,
                         input bit pe, input bit pre);
        bit go;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; pe_lvl = pe; pre_lvl = pre;
        @(negedge clk);
        cmd_valid = 1'b0; pe_lvl = 1'b0; pre_lvl = 1'b0;
        go = m_armed && pe && pre && !m_seal;
        if (go && op == 4'd7) begin m_addr = TOP; m_open = 1; end
        if (go && op == 4'd8 && m_open) begin m_addr = a; m_open = 0; end
        if (go && op == 4'd9) m_seal = 1;
        m_armed = (op == 4'd6) && m_pgm && pe && pre;
        if (op == 4'd1) m_pgm = 1;
        if (op == 4'd2) m_pgm = 0;
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < NW; a++) begin
            chk_addr = AW'(a);
            chk_pe = 1'b1;
            @(negedge clk);
            chk(req, int'(wr_ok),
                int'(m_pgm && (m_open || a < int'(m_addr))));
        end
        chk(req, int'(bulk_ok), int'(m_pgm && m_open));
        chk(req, int'(guard_addr), int'(m_addr));
        chk(req, int'(pgm_en), int'(m_pgm));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 pgm_en", int'(pgm_en), 0);
        chk("R1 guard_addr", int'(guard_addr), int'(TOP));
        sweep("R1");
        // R3 arming refused while programming disabled
        issue(4'd6, '0, 1, 1);
        issue(4'd8, 6'd10, 1, 1);
        chk("R3 arm needs pgm", int'(guard_addr), int'(TOP));
        // R2 enable
        issue(4'd1, '0, 1, 0);
        chk("R2 pgm on", int'(pgm_en), 1);
        sweep("R5 open after reset");
        // R9 chk_pe low refuses
        chk_addr = 6'd3; chk_pe = 1'b0;
        @(negedge clk);
        chk("R9 wr_ok pe low", int'(wr_ok), 0);
        chk("R9 bulk_ok pe low", int'(bulk_ok), 0);
        chk_pe = 1'b1;
        // R4 set without arm
        issue(4'd8, 6'd20, 1, 1);
        chk("R4 unarmed set", int'(guard_addr), int'(TOP));
        // R3 arm with pre low
        issue(4'd6, '0, 1, 0);
        issue(4'd8, 6'd20, 1, 1);
        chk("R3 arm pre low", int'(guard_addr), int'(TOP));
        // R4 intervening read disarms
        issue(4'd6, '0, 1, 1);
        issue(4'd0, 6'd2, 0, 0);
        issue(4'd8, 6'd20, 1, 1);
        chk("R4 intervening cmd", int'(guard_addr), int'(TOP));
        // R11 unknown code disarms
        issue(4'd6, '0, 1, 1);
        issue(4'd15, 6'd2, 1, 1);
        issue(4'd8, 6'd20, 1, 1);
        chk("R11 unknown code", int'(guard_addr), int'(TOP));
        // R4 armed but set loaded with pe low
        issue(4'd6, '0, 1, 1);
        issue(4'd8, 6'd20, 0, 1);
        chk("R4 set pe low", int'(guard_addr), int'(TOP));
        // R6 boundary set
        issue(4'd6, '0, 1, 1);
        issue(4'd8, 6'd20, 1, 1);
        chk("R6 set stored", int'(guard_addr), 20);
        sweep("R6 boundary 20");
        // R6 set refused when closed
        issue(4'd6, '0, 1, 1);
        issue(4'd8, 6'd5, 1, 1);
        chk("R6 closed set", int'(guard_addr), 20);
        // R10 reads and R11 write codes keep state
        issue(4'd5, '0, 1, 1);
        issue(4'd3, 6'd1, 1, 0);
        issue(4'd4, 6'd1, 1, 0);
        sweep("R10 R11 no state change");
        // R5 clear
        issue(4'd6, '0, 1, 1);
        issue(4'd7, TOP, 1, 1);
        sweep("R5 cleared");
        // R7 all-ones set
        issue(4'd6, '0, 1, 1);
        issue(4'd8, TOP, 1, 1);
        chk("R7 top blocked", int'(guard_addr), int'(TOP));
        sweep("R7 all ones set");
        // R8 seal
        issue(4'd6, '0, 1, 1);
        issue(4'd7, TOP, 1, 1);
        issue(4'd6, '0, 1, 1);
        issue(4'd8, 6'd40, 1, 1);
        issue(4'd6, '0, 1, 1);
        issue(4'd9, '0, 1, 1);
        issue(4'd6, '0, 1, 1);
        issue(4'd7, TOP, 1, 1);
        chk("R8 clear after seal", int'(guard_addr), 40);
        sweep("R8 sealed");
        // R2 disable
        issue(4'd2, '0, 0, 0);
        chk("R2 pgm off", int'(pgm_en), 0);
        sweep("R2 disabled");
        // R8 reset lifts the seal
        do_reset();
        issue(4'd1, '0, 1, 0);
        issue(4'd6, '0, 1, 1);
        issue(4'd8, 6'd9, 1, 1);
        chk("R8 unsealed by reset", int'(guard_addr), 9);
        sweep("R8 after reset");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule